// File: doc/BRIEF.md
# Sealed-Entry Jump Unit with Interrupt Posture

This unit resolves indirect jumps and jump-and-link operations on a capability core. It receives the target capability register together with the immediate offset, the current program counter capability and the current interrupt-enable bit. One cycle later it reports one of two outcomes. The first is a redirect, which carries the new program counter capability, the interrupt-enable bit that applies from the first target instruction onward and, for linking jumps, a return capability. The second is a fault, which carries a cause code and changes nothing.

A sealed-entry target is unsealed automatically. The jump then applies the interrupt posture that the target's object type encodes: keep, force off or force on. Every return capability is sealed as a return entry, and that entry records whether interrupts were on or off in the caller. A later return through it restores that state. The general seal and unseal instructions and the pipeline flush are outside this block.

Top module: `sej_jump_unit`

## Requirements
- R1: While rst_ni is low, every output is 0, including ie_o.
- R2: The 3-bit object type is decoded as follows. 0 is unsealed. 1 is an entry that keeps the interrupt state, 2 is an entry that turns interrupts off and 3 is an entry that turns them on. 4 is a return entry that turns interrupts off and 5 is a return entry that turns them on.
- R3: A target whose tag is clear, or whose permission bit EXEC_BIT is 0, faults. A fault asserts fault_o and deasserts redirect_o and link_we_o, and ie_o equals the ie_i of the request.
- R4: A target whose object type is 6 or 7 faults.
- R5: A target with an object type from 1 to 5 faults when the offset is nonzero, because a sealed value cannot be altered.
- R6: On a redirect, the new program counter capability has tag 1 and object type 0. It takes the permissions and bounds of the target, and its address is (target address + offset) modulo 2^AW with bit 0 cleared.
- R7: On a redirect, ie_o is 0 for object types 2 and 4 and 1 for object types 3 and 5. For object types 0 and 1 it equals ie_i. ie_o changes in the same cycle that redirect_o is high.
- R8: A jump-and-link that does not fault asserts link_we_o. The link capability takes its tag, permissions and bounds from the program counter capability. Its address is the PCC address + 2 if COMPRESSED=1 and compressed_i is 1, and + 4 otherwise, modulo 2^AW. Its object type is 5 if ie_i was 1 and 4 if ie_i was 0.
- R9: With COMPRESSED=0, a cleared target address whose bit 1 is set faults.
- R10: A target faults when its address is below the target base, or when address + minimum instruction length (2 if COMPRESSED=1, else 4) exceeds the target top.
- R11: Results appear on the cycle after valid_i. In a cycle with no request, redirect_o, fault_o and link_we_o are 0 and ie_o holds its value.
- R12: When several faults apply, cause_o reports the first one in this order: tag=1, object type=2, execute=3, sealed offset=4, alignment=5, bounds=6. A redirect reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Jump request |
| link_i | input | 1 | Request writes a return capability |
| compressed_i | input | 1 | Jump instruction is 2 bytes long |
| ie_i | input | 1 | Current interrupt-enable state |
| off_i | input | AW | Immediate offset |
| tgt_tag_i | input | 1 | Target tag |
| tgt_perm_i | input | PW | Target permissions |
| tgt_otype_i | input | 3 | Target object type |
| tgt_base_i | input | AW | Target base |
| tgt_top_i | input | AW+1 | Target top (exclusive) |
| tgt_addr_i | input | AW | Target address |
| pcc_tag_i | input | 1 | PCC tag |
| pcc_perm_i | input | PW | PCC permissions |
| pcc_base_i | input | AW | PCC base |
| pcc_top_i | input | AW+1 | PCC top |
| pcc_addr_i | input | AW | Address of the jump instruction |
| redirect_o | output | 1 | Jump taken |
| fault_o | output | 1 | Jump faulted |
| cause_o | output | 3 | Fault cause |
| ie_o | output | 1 | Interrupt-enable after the jump |
| npc_tag_o | output | 1 | New PCC tag |
| npc_perm_o | output | PW | New PCC permissions |
| npc_otype_o | output | 3 | New PCC object type |
| npc_base_o | output | AW | New PCC base |
| npc_top_o | output | AW+1 | New PCC top |
| npc_addr_o | output | AW | New PCC address |
| link_we_o | output | 1 | Link capability valid |
| link_tag_o | output | 1 | Link tag |
| link_perm_o | output | PW | Link permissions |
| link_otype_o | output | 3 | Link object type |
| link_base_o | output | AW | Link base |
| link_top_o | output | AW+1 | Link top |
| link_addr_o | output | AW | Return address |

## Verification
The bench builds two instances with AW=6 and PW=2. One has COMPRESSED=1 and the other COMPRESSED=0, so both instruction-length variants of the alignment, bounds and link-address rules run from the same stimulus. A 6-bit address space makes a full sweep of every target address possible, including the edges of a fixed target window and wrap-around of the offset and the link address. That sweep is crossed with every object type, tag value, execute-permission value, interrupt state, linking mode and a zero and a nonzero offset, which exercises every fault-priority combination.

// File: rtl/sej_pkg.sv
package sej_pkg;
  localparam int unsigned OTW = 3;

  localparam logic [OTW-1:0] OT_UNSEALED = 3'd0;
  localparam logic [OTW-1:0] OT_ENT_KEEP = 3'd1;
  localparam logic [OTW-1:0] OT_ENT_OFF  = 3'd2;
  localparam logic [OTW-1:0] OT_ENT_ON   = 3'd3;
  localparam logic [OTW-1:0] OT_RET_OFF  = 3'd4;
  localparam logic [OTW-1:0] OT_RET_ON   = 3'd5;

  typedef enum logic [1:0] {
    POST_KEEP = 2'd0,
    POST_OFF  = 2'd1,
    POST_ON   = 2'd2
  } posture_e;

  // order of values is the reporting priority
  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TAG    = 3'd1,
    CAUSE_OTYPE  = 3'd2,
    CAUSE_EXEC   = 3'd3,
    CAUSE_SEALOF = 3'd4,
    CAUSE_ALIGN  = 3'd5,
    CAUSE_BOUNDS = 3'd6
  } cause_e;
endpackage

// File: rtl/sej_otype_dec.sv
module sej_otype_dec
  import sej_pkg::*;
(
  input  logic [OTW-1:0] otype_i,
  output logic           legal_o,
  output logic           sealed_o,
  output posture_e       posture_o
);
  always_comb begin
    legal_o   = 1'b1;
    sealed_o  = 1'b1;
    posture_o = POST_KEEP;
    unique case (otype_i)
      OT_UNSEALED: sealed_o  = 1'b0;
      OT_ENT_KEEP: posture_o = POST_KEEP;
      OT_ENT_OFF:  posture_o = POST_OFF;
      OT_ENT_ON:   posture_o = POST_ON;
      OT_RET_OFF:  posture_o = POST_OFF;
      OT_RET_ON:   posture_o = POST_ON;
      default:     legal_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/sej_target_chk.sv
module sej_target_chk
  import sej_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned PW         = 12,
  parameter int unsigned EXEC_BIT   = 0,
  parameter bit          COMPRESSED = 1'b1
) (
  input  logic           tag_i,
  input  logic [PW-1:0]  perm_i,
  input  logic [OTW-1:0] otype_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW:0]    top_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  off_i,
  output logic [AW-1:0]  tgt_o,
  output posture_e       posture_o,
  output cause_e         cause_o
);
  localparam int unsigned ILEN_MIN = COMPRESSED ? 2 : 4;
  localparam logic [AW:0] ILEN_EXT = (AW+1)'(ILEN_MIN);

  logic legal, sealed;
  logic [AW-1:0] sum;
  logic misalign, out_lo, out_hi;

  sej_otype_dec u_dec (
    .otype_i  (otype_i),
    .legal_o  (legal),
    .sealed_o (sealed),
    .posture_o(posture_o)
  );

  assign sum   = addr_i + off_i;
  assign tgt_o = {sum[AW-1:1], 1'b0};

  generate
    if (COMPRESSED) begin : g_align16
      assign misalign = 1'b0;
    end else begin : g_align32
      assign misalign = tgt_o[1];
    end
  endgenerate

  assign out_lo = tgt_o < base_i;
  assign out_hi = ({1'b0, tgt_o} + ILEN_EXT) > top_i;

  always_comb begin
    if (!tag_i)                         cause_o = CAUSE_TAG;
    else if (!legal)                    cause_o = CAUSE_OTYPE;
    else if (!perm_i[EXEC_BIT])         cause_o = CAUSE_EXEC;
    else if (sealed && (off_i != '0))   cause_o = CAUSE_SEALOF;
    else if (misalign)                  cause_o = CAUSE_ALIGN;
    else if (out_lo || out_hi)          cause_o = CAUSE_BOUNDS;
    else                                cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/sej_link_gen.sv
module sej_link_gen
  import sej_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter bit          COMPRESSED = 1'b1
) (
  input  logic [AW-1:0]  pc_i,
  input  logic           compressed_i,
  input  logic           ie_i,
  output logic [AW-1:0]  ret_addr_o,
  output logic [OTW-1:0] ret_otype_o
);
  logic [AW-1:0] step;

  generate
    if (COMPRESSED) begin : g_var_len
      assign step = compressed_i ? AW'(2) : AW'(4);
    end else begin : g_fix_len
      logic unused_len;
      assign unused_len = compressed_i;
      assign step = AW'(4);
    end
  endgenerate

  assign ret_addr_o  = pc_i + step;
  assign ret_otype_o = ie_i ? OT_RET_ON : OT_RET_OFF;
endmodule

// File: rtl/sej_jump_unit.sv
module sej_jump_unit
  import sej_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned PW         = 12,
  parameter int unsigned EXEC_BIT   = 0,
  parameter bit          COMPRESSED = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           link_i,
  input  logic           compressed_i,
  input  logic           ie_i,
  input  logic [AW-1:0]  off_i,
  input  logic           tgt_tag_i,
  input  logic [PW-1:0]  tgt_perm_i,
  input  logic [2:0]     tgt_otype_i,
  input  logic [AW-1:0]  tgt_base_i,
  input  logic [AW:0]    tgt_top_i,
  input  logic [AW-1:0]  tgt_addr_i,
  input  logic           pcc_tag_i,
  input  logic [PW-1:0]  pcc_perm_i,
  input  logic [AW-1:0]  pcc_base_i,
  input  logic [AW:0]    pcc_top_i,
  input  logic [AW-1:0]  pcc_addr_i,
  output logic           redirect_o,
  output logic           fault_o,
  output logic [2:0]     cause_o,
  output logic           ie_o,
  output logic           npc_tag_o,
  output logic [PW-1:0]  npc_perm_o,
  output logic [2:0]     npc_otype_o,
  output logic [AW-1:0]  npc_base_o,
  output logic [AW:0]    npc_top_o,
  output logic [AW-1:0]  npc_addr_o,
  output logic           link_we_o,
  output logic           link_tag_o,
  output logic [PW-1:0]  link_perm_o,
  output logic [2:0]     link_otype_o,
  output logic [AW-1:0]  link_base_o,
  output logic [AW:0]    link_top_o,
  output logic [AW-1:0]  link_addr_o
);
  logic [AW-1:0]  tgt;
  posture_e       posture;
  cause_e         cause;
  logic [AW-1:0]  ret_addr;
  logic [OTW-1:0] ret_otype;
  logic           ok, ie_next;

  sej_target_chk #(
    .AW(AW), .PW(PW), .EXEC_BIT(EXEC_BIT), .COMPRESSED(COMPRESSED)
  ) u_chk_tgt (
    .tag_i    (tgt_tag_i),
    .perm_i   (tgt_perm_i),
    .otype_i  (tgt_otype_i),
    .base_i   (tgt_base_i),
    .top_i    (tgt_top_i),
    .addr_i   (tgt_addr_i),
    .off_i    (off_i),
    .tgt_o    (tgt),
    .posture_o(posture),
    .cause_o  (cause)
  );

  sej_link_gen #(
    .AW(AW), .COMPRESSED(COMPRESSED)
  ) u_link (
    .pc_i        (pcc_addr_i),
    .compressed_i(compressed_i),
    .ie_i        (ie_i),
    .ret_addr_o  (ret_addr),
    .ret_otype_o (ret_otype)
  );

  assign ok = (cause == CAUSE_NONE);

  always_comb begin
    unique case (posture)
      POST_OFF: ie_next = 1'b0;
      POST_ON:  ie_next = 1'b1;
      default:  ie_next = ie_i;
    endcase
    if (!ok) ie_next = ie_i;
  end

  // status and posture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      fault_o    <= 1'b0;
      cause_o    <= '0;
      link_we_o  <= 1'b0;
      ie_o       <= 1'b0;
    end else begin
      redirect_o <= valid_i && ok;
      fault_o    <= valid_i && !ok;
      cause_o    <= valid_i ? cause : CAUSE_NONE;
      link_we_o  <= valid_i && ok && link_i;
      if (valid_i) ie_o <= ie_next;
    end
  end

  // new program counter capability
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_tag_o   <= 1'b0;
      npc_perm_o  <= '0;
      npc_otype_o <= '0;
      npc_base_o  <= '0;
      npc_top_o   <= '0;
      npc_addr_o  <= '0;
    end else if (valid_i && ok) begin
      npc_tag_o   <= 1'b1;
      npc_perm_o  <= tgt_perm_i;
      npc_otype_o <= OT_UNSEALED;
      npc_base_o  <= tgt_base_i;
      npc_top_o   <= tgt_top_i;
      npc_addr_o  <= tgt;
    end
  end

  // return capability
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_tag_o   <= 1'b0;
      link_perm_o  <= '0;
      link_otype_o <= '0;
      link_base_o  <= '0;
      link_top_o   <= '0;
      link_addr_o  <= '0;
    end else if (valid_i && ok && link_i) begin
      link_tag_o   <= pcc_tag_i;
      link_perm_o  <= pcc_perm_i;
      link_otype_o <= ret_otype;
      link_base_o  <= pcc_base_i;
      link_top_o   <= pcc_top_i;
      link_addr_o  <= ret_addr;
    end
  end
endmodule

// File: rtl/sej_jump_unit_chk.sv
module sej_jump_unit_chk #(
  parameter int unsigned AW         = 32,
  parameter bit          COMPRESSED = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ie_i,
  input logic [2:0]    tgt_otype_i,
  input logic          redirect_o,
  input logic          fault_o,
  input logic          ie_o,
  input logic          npc_tag_o,
  input logic [2:0]    npc_otype_o,
  input logic [AW-1:0] npc_addr_o,
  input logic          link_we_o,
  input logic [2:0]    link_otype_o
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({redirect_o, fault_o})); // R11

  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!redirect_o && !link_we_o)); // R3

  AST_FAULT_IE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (ie_o == $past(ie_i))); // R3

  AST_NPC_UNSEALED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (npc_tag_o && npc_otype_o == 3'd0)); // R6

  AST_OFF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && ($past(tgt_otype_i) == 3'd2 || $past(tgt_otype_i) == 3'd4)) |-> !ie_o); // R7

  AST_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && ($past(tgt_otype_i) == 3'd3 || $past(tgt_otype_i) == 3'd5)) |-> ie_o); // R7

  AST_LINK_POSTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_otype_o == ($past(ie_i) ? 3'd5 : 3'd4))); // R8

  AST_LINK_WITH_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> redirect_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> (!redirect_o && !fault_o && $stable(ie_o))); // R11

  generate
    if (!COMPRESSED) begin : g_align
      AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> (npc_addr_o[1:0] == 2'b00)); // R9
    end
  endgenerate
endmodule

bind sej_jump_unit sej_jump_unit_chk #(.AW(AW), .COMPRESSED(COMPRESSED)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ie_i        (ie_i),
  .tgt_otype_i (tgt_otype_i),
  .redirect_o  (redirect_o),
  .fault_o     (fault_o),
  .ie_o        (ie_o),
  .npc_tag_o   (npc_tag_o),
  .npc_otype_o (npc_otype_o),
  .npc_addr_o  (npc_addr_o),
  .link_we_o   (link_we_o),
  .link_otype_o(link_otype_o)
);

// File: tb/sim_sej_jump_unit.sv
`timescale 1ns/1ps
module sim_sej_jump_unit;
  localparam int AW = 6;
  localparam int PW = 2;
  localparam int TBASE = 8;
  localparam int TTOP  = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic valid, link, comp, ie, ttag;
  logic [AW-1:0] off, tbase, taddr, pbase, paddr;
  logic [PW-1:0] tperm, pperm;
  logic [2:0] totype;
  logic [AW:0] ttop, ptop;

  logic          rd[2], ft[2], ieo[2], nt[2], lwe[2], lt[2];
  logic [2:0]    cs[2], no[2], lo[2];
  logic [PW-1:0] np[2], lp[2];
  logic [AW-1:0] nb[2], na[2], lb[2], la[2];
  logic [AW:0]   ntp[2], ltp[2];

  sej_jump_unit #(.AW(AW), .PW(PW), .EXEC_BIT(0), .COMPRESSED(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .link_i(link), .compressed_i(comp),
    .ie_i(ie), .off_i(off), .tgt_tag_i(ttag), .tgt_perm_i(tperm), .tgt_otype_i(totype),
    .tgt_base_i(tbase), .tgt_top_i(ttop), .tgt_addr_i(taddr), .pcc_tag_i(1'b1),
    .pcc_perm_i(pperm), .pcc_base_i(pbase), .pcc_top_i(ptop), .pcc_addr_i(paddr),
    .redirect_o(rd[0]), .fault_o(ft[0]), .cause_o(cs[0]), .ie_o(ieo[0]),
    .npc_tag_o(nt[0]), .npc_perm_o(np[0]), .npc_otype_o(no[0]), .npc_base_o(nb[0]),
    .npc_top_o(ntp[0]), .npc_addr_o(na[0]), .link_we_o(lwe[0]), .link_tag_o(lt[0]),
    .link_perm_o(lp[0]), .link_otype_o(lo[0]), .link_base_o(lb[0]), .link_top_o(ltp[0]),
    .link_addr_o(la[0]));

  sej_jump_unit #(.AW(AW), .PW(PW), .EXEC_BIT(0), .COMPRESSED(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .link_i(link), .compressed_i(comp),
    .ie_i(ie), .off_i(off), .tgt_tag_i(ttag), .tgt_perm_i(tperm), .tgt_otype_i(totype),
    .tgt_base_i(tbase), .tgt_top_i(ttop), .tgt_addr_i(taddr), .pcc_tag_i(1'b1),
    .pcc_perm_i(pperm), .pcc_base_i(pbase), .pcc_top_i(ptop), .pcc_addr_i(paddr),
    .redirect_o(rd[1]), .fault_o(ft[1]), .cause_o(cs[1]), .ie_o(ieo[1]),
    .npc_tag_o(nt[1]), .npc_perm_o(np[1]), .npc_otype_o(no[1]), .npc_base_o(nb[1]),
    .npc_top_o(ntp[1]), .npc_addr_o(na[1]), .link_we_o(lwe[1]), .link_tag_o(lt[1]),
    .link_perm_o(lp[1]), .link_otype_o(lo[1]), .link_base_o(lb[1]), .link_top_o(ltp[1]),
    .link_addr_o(la[1]));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (n_bad <= 40) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // expected results for one instance (c = compressed support)
  task automatic verify(input int i, input int c, input int t_tag, input int pex,
                        input int ot, input int iei, input int lnk, input int cmp,
                        input int ta, input int of, input int pa, input int iprev);
    int t, ilen, cause, exp_ie, step;
    t = ((ta + of) % 64) & 62;
    ilen = c ? 2 : 4;
    if (t_tag == 0)                     cause = 1;
    else if (ot > 5)                    cause = 2;
    else if (pex == 0)                  cause = 3;
    else if (ot != 0 && of != 0)        cause = 4;
    else if (c == 0 && (t & 2) != 0)    cause = 5;
    else if (t < TBASE || t + ilen > TTOP) cause = 6;
    else                                cause = 0;
    if (cause != 0)              exp_ie = iei;
    else if (ot == 2 || ot == 4) exp_ie = 0;
    else if (ot == 3 || ot == 5) exp_ie = 1;
    else                         exp_ie = iei;
    chk(int'(cs[i]) == cause, "R12 cause", int'(cs[i]), cause);
    chk(ft[i] == (cause != 0) && rd[i] == (cause == 0), "R3 R4 R5 R9 R10 outcome",
        {rd[i], ft[i]}, (cause == 0) ? 2 : 1);
    chk(int'(ieo[i]) == exp_ie, "R7 ie_o", int'(ieo[i]), exp_ie);
    chk(int'(lwe[i]) == ((cause == 0 && lnk != 0) ? 1 : 0), "R8 link_we", int'(lwe[i]),
        (cause == 0 && lnk != 0) ? 1 : 0);
    if (cause == 0) begin
      chk(int'(na[i]) == t, "R6 npc addr", int'(na[i]), t);
      chk(nt[i] == 1'b1 && no[i] == 3'd0, "R6 npc unsealed", {nt[i], no[i]}, 8);
      chk(int'(nb[i]) == TBASE && int'(ntp[i]) == TTOP && np[i] == tperm, "R6 npc bounds",
          int'(nb[i]), TBASE);
    end
    if (cause == 0 && lnk != 0) begin
      step = (c != 0 && cmp != 0) ? 2 : 4;
      chk(int'(la[i]) == (pa + step) % 64, "R8 link addr", int'(la[i]), (pa + step) % 64);
      chk(int'(lo[i]) == (iei ? 5 : 4), "R8 link otype", int'(lo[i]), iei ? 5 : 4);
      chk(lt[i] == 1'b1 && lb[i] == pbase && ltp[i] == ptop && lp[i] == pperm,
          "R8 link fields", int'(lb[i]), int'(pbase));
    end
    if (iprev < 0) chk(1'b1, "R2", 0, 0);
  endtask

  initial begin
    valid = 0; link = 0; comp = 0; ie = 0; ttag = 0; off = '0;
    tbase = AW'(TBASE); ttop = (AW+1)'(TTOP); taddr = '0; tperm = '0; totype = '0;
    pbase = '0; ptop = 7'd64; pperm = 2'b11; paddr = '0;
    repeat (3) @(negedge clk);
    valid = 1; ttag = 1; tperm = 2'b11;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk({rd[i], ft[i], lwe[i], ieo[i], nt[i], lt[i]} == '0 && cs[i] == 0 && na[i] == 0
          && la[i] == 0 && lo[i] == 0, "R1 reset", int'({rd[i], ft[i], ieo[i]}), 0);
    end
    valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int tg = 0; tg < 2; tg++)
    for (int px = 0; px < 2; px++)
    for (int ot = 0; ot < 8; ot++)
    for (int iv = 0; iv < 2; iv++)
    for (int lk = 0; lk < 2; lk++)
    for (int oi = 0; oi < 2; oi++)
    for (int ta = 0; ta < 64; ta++) begin
      int of, pa, cm;
      logic ie_before[2];
      of = oi ? 3 : 0;
      pa = (ta * 7 + 5) % 64;
      cm = ta & 1;
      valid = 1; link = lk[0]; comp = cm[0]; ie = iv[0]; ttag = tg[0];
      tperm = {1'b1, px[0]}; totype = ot[2:0]; taddr = AW'(ta); off = AW'(of);
      paddr = AW'(pa);
      @(negedge clk);
      verify(0, 1, tg, px, ot, iv, lk, cm, ta, of, pa, 0);
      verify(1, 0, tg, px, ot, iv, lk, cm, ta, of, pa, 0);
      // idle cycle with opposite ie_i and otype: nothing may move (R11)
      ie_before[0] = ieo[0];
      ie_before[1] = ieo[1];
      valid = 0; ie = ~iv[0]; totype = 3'd3;
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        chk(!rd[i] && !ft[i] && !lwe[i] && ieo[i] == ie_before[i], "R11 idle",
            int'({rd[i], ft[i], lwe[i], ieo[i]}), int'(ie_before[i]));
    end
    finish_run();
  end
endmodule